// File: doc/BRIEF.md
# Phase-Offset Slave PWM Timebase

This block is a slave timebase for one bridge of a multi-bridge phase-shift converter. A master timebase elsewhere emits a single-cycle sync pulse each time its counter wraps to zero. On each sync pulse the slave reloads its own period counter with a programmed phase value. The sign of that value sets the counting direction until the next sync. A non-negative command counts down, so the slave output lags the master. A negative command counts up, so the slave output leads the master.

The controller writes a signed 16-bit phase command with a one-cycle strobe. The block first takes the magnitude of the command and limits it to a quarter of the switching period. It then splits the result into a coarse part of whole clock cycles and a fine sub-cycle code. The coarse part is lowered by the fixed two-cycle internal latency, and it never goes below zero. The shaped value waits in a shadow register and takes effect only at the next sync pulse, so a write never disturbs a running period. The outputs are a 50 % duty gate signal, the coarse counter value, and an 8-bit fine-delay code. An external edge-delay element applies that code to both edges of the gate.

With the default parameters the period is 1000 clock cycles, which gives a 100 kHz output from a 100 MHz clock. The quarter-period limit is then 250 coarse cycles.

Top module: `phs_slave_timebase`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, count_out is 0, gate_out is 1 and fine_code is 0. The active shadow direction is count-down and the shadow load value is 0.
- R2: A command strobe (cmd_valid=1) changes no output until the next sync pulse. If a sync pulse and a strobe occur in the same cycle, the sync uses the shadow content from before that strobe.
- R3: In the cycle after sync_in=1, count_out equals the coarse load value held in the shadow register when the sync occurred.
- R4: The coarse load value is bits 15:6 of the limited magnitude of phase_cmd minus 2. If that difference would be negative, the load value is 0.
- R5: The magnitude of phase_cmd (two's complement) is limited to 16000, which is 250 coarse cycles with a fine part of 0. Any larger magnitude, including that of -32768, is replaced by 16000.
- R6: After a sync with a non-negative command (phase_cmd bit 15 = 0), count_out decreases by 1 each cycle. From 0 it wraps to 999.
- R7: After a sync with a negative command (bit 15 = 1), the magnitude is loaded and count_out increases by 1 each cycle. From 999 it wraps to 0.
- R8: gate_out is 1 exactly while count_out is below 500, which is half the period. It therefore changes at every wrap and at every half-period crossing.
- R9: fine_code[7:2] holds bits 5:0 of the limited magnitude and fine_code[1:0] is 0. fine_code changes only in the cycle after a sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_cmd | input | 16 | Signed phase command; upper 10 bits are coarse cycles, lower 6 bits are the fine code |
| cmd_valid | input | 1 | Strobe that writes phase_cmd into the shadow register |
| sync_in | input | 1 | Single-cycle pulse from the master at its counter wrap |
| gate_out | output | 1 | 50 % duty square-wave gate |
| count_out | output | 10 | Coarse period counter |
| fine_code | output | 8 | Sub-cycle delay code for both gate edges |

## Verification
The assertions are checked on every cycle. They check that the counter stays within the period and steps by exactly one in the active direction, wrapping at each end. They also check that the gate tracks the half-period comparison, that the counter takes the shadow load value one cycle after a sync, and that the fine code holds still without a sync. The bench scenarios cover the rest. They show that the limiter, the coarse/fine split and the saturating offset produce the right numbers for specific commands, including the 16000 boundary and -32768. They also show that a strobe alone leaves every output untouched, and that a strobe in the same cycle as a sync is deferred to the following sync.

// File: rtl/phs_pkg.sv
package phs_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } phs_dir_e;
endpackage

// File: rtl/phs_cmd_shaper.sv
module phs_cmd_shaper
  import phs_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int FINE_W = 6,
  parameter int PERIOD = 1000,
  parameter int OFFSET = 2,
  localparam int COARSE_W = CMD_W - FINE_W
) (
  input  logic [CMD_W-1:0]    cmd,
  output logic [COARSE_W-1:0] load_val,
  output logic [FINE_W-1:0]   fine_val,
  output phs_dir_e            dir
);
  localparam int unsigned LIM_MAG = (PERIOD / 4) << FINE_W;
  localparam logic [CMD_W:0] LIM_V = (CMD_W+1)'(LIM_MAG);
  localparam logic [COARSE_W-1:0] OFF_V = COARSE_W'(OFFSET);

  // two's complement magnitude, one bit wider so that the most negative value fits
  function automatic logic [CMD_W:0] magnitude(input logic [CMD_W-1:0] c);
    if (c[CMD_W-1]) return ({1'b0, ~c} + (CMD_W+1)'(1));
    else return {1'b0, c};
  endfunction

  // quarter-period limiter
  function automatic logic [CMD_W-1:0] limit(input logic [CMD_W:0] m);
    if (m > LIM_V) return LIM_V[CMD_W-1:0];
    else return m[CMD_W-1:0];
  endfunction

  // offset compensation, saturating at zero
  function automatic logic [COARSE_W-1:0] sat_offset(input logic [COARSE_W-1:0] c);
    if (c > OFF_V) return c - OFF_V;
    else return '0;
  endfunction

  logic [CMD_W:0]   mag;
  logic [CMD_W-1:0] lim_mag;

  always_comb begin
    mag      = magnitude(cmd);
    lim_mag  = limit(mag);
    load_val = sat_offset(lim_mag[CMD_W-1:FINE_W]);
    fine_val = lim_mag[FINE_W-1:0];
    dir      = cmd[CMD_W-1] ? DIR_UP : DIR_DOWN;
  end
endmodule

// File: rtl/phs_phase_shadow.sv
module phs_phase_shadow
  import phs_pkg::*;
#(
  parameter int COARSE_W = 10,
  parameter int FINE_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                commit,
  input  logic [COARSE_W-1:0] wr_load,
  input  logic [FINE_W-1:0]   wr_fine,
  input  phs_dir_e            wr_dir,
  output logic [COARSE_W-1:0] sh_load,
  output phs_dir_e            act_dir,
  output logic [FINE_W-1:0]   act_fine
);
  logic [FINE_W-1:0] sh_fine;
  phs_dir_e          sh_dir;

  // shadow stage: written by the controller strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_load <= '0;
      sh_fine <= '0;
      sh_dir  <= DIR_DOWN;
    end else if (wr_en) begin
      sh_load <= wr_load;
      sh_fine <= wr_fine;
      sh_dir  <= wr_dir;
    end
  end

  // active stage: takes the shadow content at each sync
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_dir  <= DIR_DOWN;
      act_fine <= '0;
    end else if (commit) begin
      act_dir  <= sh_dir;
      act_fine <= sh_fine;
    end
  end
endmodule

// File: rtl/phs_counter.sv
module phs_counter
  import phs_pkg::*;
#(
  parameter int PERIOD = 1000,
  localparam int CNT_W = $clog2(PERIOD),
  localparam int HALF  = PERIOD / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_evt,
  input  logic [CNT_W-1:0] load_val,
  input  phs_dir_e         dir,
  output logic [CNT_W-1:0] cnt,
  output logic             gate
);
  localparam logic [CNT_W-1:0] TOP_V  = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] HALF_V = CNT_W'(HALF);

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c, input phs_dir_e d);
    if (d == DIR_UP) return (c == TOP_V) ? '0 : c + CNT_W'(1);
    else return (c == '0) ? TOP_V : c - CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (load_evt) cnt_nxt = load_val;
    else cnt_nxt = step(cnt, dir);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      gate <= 1'b1;
    end else begin
      cnt  <= cnt_nxt;
      gate <= (cnt_nxt < HALF_V);
    end
  end
endmodule

// File: rtl/phs_slave_timebase.sv
module phs_slave_timebase
  import phs_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int FINE_W = 6,
  parameter int EXT_W  = 8,
  parameter int PERIOD = 1000,
  parameter int OFFSET = 2,
  localparam int CNT_W    = $clog2(PERIOD),
  localparam int COARSE_W = CMD_W - FINE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] phase_cmd,
  input  logic             cmd_valid,
  input  logic             sync_in,
  output logic             gate_out,
  output logic [CNT_W-1:0] count_out,
  output logic [EXT_W-1:0] fine_code
);
  logic [COARSE_W-1:0] shaped_load;
  logic [FINE_W-1:0]   shaped_fine;
  phs_dir_e            shaped_dir;
  logic [COARSE_W-1:0] shadow_coarse;
  phs_dir_e            active_dir;
  logic [FINE_W-1:0]   active_fine;

  // named internal events for the checker
  logic             dir_up_w;
  logic [CNT_W-1:0] shadow_load_w;

  phs_cmd_shaper #(
    .CMD_W(CMD_W), .FINE_W(FINE_W), .PERIOD(PERIOD), .OFFSET(OFFSET)
  ) u_shaper (
    .cmd(phase_cmd), .load_val(shaped_load), .fine_val(shaped_fine), .dir(shaped_dir)
  );

  phs_phase_shadow #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(cmd_valid), .commit(sync_in),
    .wr_load(shaped_load), .wr_fine(shaped_fine), .wr_dir(shaped_dir),
    .sh_load(shadow_coarse), .act_dir(active_dir), .act_fine(active_fine)
  );

  assign shadow_load_w = CNT_W'(shadow_coarse);
  assign dir_up_w      = (active_dir == DIR_UP);

  phs_counter #(.PERIOD(PERIOD)) u_counter (
    .clk(clk), .rst_n(rst_n), .load_evt(sync_in), .load_val(shadow_load_w),
    .dir(active_dir), .cnt(count_out), .gate(gate_out)
  );

  // fine code sits in the upper bits of the extension field
  assign fine_code = EXT_W'(active_fine) << (EXT_W - FINE_W);
endmodule

// File: rtl/phs_slave_checker.sv
module phs_slave_checker #(
  parameter int FINE_W = 6,
  parameter int EXT_W  = 8,
  parameter int PERIOD = 1000,
  localparam int CNT_W = $clog2(PERIOD),
  localparam int HALF  = PERIOD / 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_in,
  input logic             gate_out,
  input logic [CNT_W-1:0] count_out,
  input logic [EXT_W-1:0] fine_code,
  input logic             dir_up,
  input logic [CNT_W-1:0] shadow_load
);
  // R3
  sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> count_out == $past(shadow_load));

  // R6
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_in && !dir_up) |=>
      int'(count_out) == (($past(count_out) == '0) ? PERIOD - 1 : int'($past(count_out)) - 1));

  // R7
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_in && dir_up) |=>
      int'(count_out) == ((int'($past(count_out)) == PERIOD - 1) ? 0 : int'($past(count_out)) + 1));

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_out) < PERIOD);

  // R8
  gate_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_out == (int'(count_out) < HALF));

  // R9
  fine_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_in |=> $stable(fine_code));

  // R9
  fine_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fine_code[EXT_W-FINE_W-1:0] == '0);
endmodule

bind phs_slave_timebase phs_slave_checker #(
  .FINE_W(FINE_W), .EXT_W(EXT_W), .PERIOD(PERIOD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .gate_out(gate_out),
  .count_out(count_out), .fine_code(fine_code), .dir_up(dir_up_w),
  .shadow_load(shadow_load_w)
);

// File: tb/test_phs_slave_timebase.sv
module test_phs_slave_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cmd = 16'h0;
  logic        vld = 1'b0;
  logic        sync = 1'b0;
  logic        running = 1'b0;
  wire         gate;
  wire  [9:0]  cnt;
  wire  [7:0]  fine;

  int vectors = 0;
  int errs = 0;

  // behavioural reference state
  int m_cnt, m_up, m_fine, s_load, s_up, s_fine;

  always #4 clk = ~clk;

  phs_slave_timebase i_phs_slave_timebase (
    .clk(clk), .rst_n(rst_n), .phase_cmd(cmd), .cmd_valid(vld), .sync_in(sync),
    .gate_out(gate), .count_out(cnt), .fine_code(fine)
  );

  function automatic void shape(input logic [15:0] c, output int ld, output int up, output int fn);
    int v, mag;
    v = int'($signed(c));
    up = (v < 0) ? 1 : 0;
    mag = (v < 0) ? -v : v;
    if (mag > 16000) mag = 16000;
    ld = mag / 64 - 2;
    if (ld < 0) ld = 0;
    fn = (mag % 64) * 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_up <= 0; m_fine <= 0; s_load <= 0; s_up <= 0; s_fine <= 0;
    end else begin
      int a, b, c;
      if (sync) begin
        m_cnt <= s_load; m_up <= s_up; m_fine <= s_fine;
      end else if (m_up != 0) m_cnt <= (m_cnt == 999) ? 0 : m_cnt + 1;
      else m_cnt <= (m_cnt == 0) ? 999 : m_cnt - 1;
      if (vld) begin
        shape(cmd, a, b, c);
        s_load <= a; s_up <= b; s_fine <= c;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (running) begin
      check("R3/R6/R7 count_out vs model", int'(cnt), m_cnt);
      check("R8 gate_out vs model", int'(gate), (m_cnt < 500) ? 1 : 0);
      check("R9 fine_code vs model", int'(fine), m_fine);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cmd(input logic [15:0] v);
    cmd = v; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic pulse_sync();
    sync = 1'b1;
    @(negedge clk);
    sync = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    wait_cyc(3);
    // R1: values held during reset
    check("R1 reset count", int'(cnt), 0);
    check("R1 reset gate", int'(gate), 1);
    check("R1 reset fine", int'(fine), 0);
    rst_n = 1'b1;
    running = 1'b1;
    wait_cyc(1);
    check("R1 free count after reset", int'(cnt), 999);

    // R2: strobe alone leaves every output untouched
    write_cmd(16'h0145);
    wait_cyc(4);
    check("R2 fine unchanged without sync", int'(fine), 0);
    check("R2 count keeps running", int'(cnt), 994);

    // R3 R4 R9: positive command 325 -> load 3, fine 0x14
    pulse_sync();
    check("R4 load after sync", int'(cnt), 3);
    check("R9 fine after sync", int'(fine), 8'h14);
    wait_cyc(4);
    check("R6 wrap down", int'(cnt), 999);
    check("R8 gate low after wrap", int'(gate), 0);

    // R7: -325 counts up from 3
    write_cmd(16'hFEBB);
    pulse_sync();
    check("R7 negative load", int'(cnt), 3);
    check("R9 negative fine", int'(fine), 8'h14);
    wait_cyc(996);
    check("R7 up reaches top", int'(cnt), 999);
    wait_cyc(1);
    check("R7 wrap up", int'(cnt), 0);
    check("R8 gate high after wrap", int'(gate), 1);

    // R5: limiter boundaries
    write_cmd(16'h3E80);
    pulse_sync();
    check("R5 exact limit load", int'(cnt), 248);
    write_cmd(16'h3E81);
    pulse_sync();
    check("R5 just over limit fine", int'(fine), 0);
    write_cmd(16'h4E20);
    pulse_sync();
    check("R5 clamp 20000", int'(cnt), 248);
    write_cmd(16'h8000);
    pulse_sync();
    check("R5 clamp -32768", int'(cnt), 248);
    wait_cyc(1);
    check("R7 most negative counts up", int'(cnt), 249);

    // R4: saturating offset
    write_cmd(16'h0040);
    pulse_sync();
    check("R4 coarse 1 saturates", int'(cnt), 0);
    write_cmd(16'h0083);
    pulse_sync();
    check("R4 coarse 2 gives 0", int'(cnt), 0);
    check("R9 fine 3", int'(fine), 12);

    // R2: strobe in the same cycle as sync is deferred
    write_cmd(16'h0145);
    cmd = 16'h0200; vld = 1'b1; sync = 1'b1;
    @(negedge clk);
    vld = 1'b0; sync = 1'b0;
    check("R2 same-cycle uses old shadow", int'(cnt), 3);
    wait_cyc(10);
    pulse_sync();
    check("R2 deferred command applied", int'(cnt), 6);
    check("R9 deferred fine", int'(fine), 0);

    // periodic sync from a master, lagging by 100 coarse cycles
    write_cmd(16'h1980);
    for (int p = 0; p < 3; p++) begin
      pulse_sync();
      check("R3 periodic reload", int'(cnt), 100);
      wait_cyc(999);
    end

    running = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule